// File: doc/BRIEF.md
# Five-Level Pulser Channel Control Sequencer

This block is the digital control for one channel of a multi-level high-voltage ultrasound transmitter. Each cycle it reads a 3-bit channel code (a rail-select bit, a negative-drive bit and a positive-drive bit) together with the chip-wide mode, power-scale, output-enable, regulator-enable and over-temperature inputs. From these it produces a one-hot command for the output stage: high rail of pair 0 or 1, low rail of pair 0 or 1, return-to-zero, or high impedance.

It also drives four analog switch enables: the return-to-zero bleed switch, the transmit/receive switch, the receive damper and the continuous-wave (CW) switch. Each switch follows a decoded target state after its own turn-on or turn-off delay, counted in system-clock cycles. A switch change that is still pending is dropped if the target returns to the current state before the count runs out. Any disable condition puts every switch into its safe state at the next clock edge, with no delay.

An optional retiming register samples the channel code on the clock. It is used when retimed operation is selected and an external clock-activity detector reports that the clock is running. Otherwise the code passes straight through. A sticky error flag records two protocol faults: a transmit code that directly follows a receive code, and drive activity in retimed mode before the clock has been detected.

Top module: `pulser_chan_ctrl`

## Requirements
- R1: `stage_o` is one-hot with bit 0 = high rail 0, bit 1 = high rail 1, bit 2 = low rail 0, bit 3 = low rail 1, bit 4 = return-to-zero, bit 5 = high impedance. When the channel is enabled and `mode_i`=0, code {sel,neg,pos} 000 and 100 give return-to-zero, 001 gives high rail 0, 010 gives low rail 0, 101 gives high rail 1, 110 gives low rail 1, and 111 gives high impedance.
- R2: When the channel is enabled, code 011 is the receive state. The stage is return-to-zero, the targets of the T/R and bleed switches are on, and the damper target is off. Every other enabled code sets the T/R and bleed targets off and the damper target on.
- R3: With `mode_i`=1, every code except 011 gives high impedance and sets the CW target on. Code 011 gives the receive state of R2 with the CW target off. With `mode_i`=0 the CW target is always off.
- R4: If `otp_n_i`, `reg_en_i` or `oe_i` is low, the stage is high impedance in the same cycle. The inputs rank in that order of priority, and all three give the same result. At the next clock edge the T/R, bleed and CW switches are off and the damper is on, with no delay count.
- R5: `rail1_reduced_o` is 1 exactly when the channel is enabled, `mode_i`=0 and `pscale_i`=0. `pscale_i` never changes `stage_o`.
- R6: The T/R switch follows its target after TR_ON edges (turn-on) or TR_OFF edges (turn-off). The bleed switch does the same with BLEED_ON and BLEED_OFF.
- R7: The damper switch turns on DMP_ON edges and turns off DMP_OFF edges after its target changes.
- R8: The CW switch turns on CW_ON edges and turns off CW_OFF edges after its target changes.
- R9: If a switch's target returns to the switch's current state before the delay expires, the pending change is cancelled and its count restarts from zero.
- R10: When `retime_mode_i` and `rclk_seen_i` are both 1, the decoded code is the one registered at the previous clock edge. Otherwise the code is used combinationally.
- R11: `err_o` sets one edge after a transmit code (001, 010, 101, 110) is applied in the cycle after code 011, with no 000 in between. It stays set until reset.
- R12: `err_o` also sets one edge after a cycle in which `retime_mode_i`=1, `rclk_seen_i`=0 and `neg_i` or `pos_i` is 1.
- R13: During and after reset the T/R, bleed and CW switches are off, the damper is on and `err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and retiming clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Rail-pair select bit of the channel code |
| neg_i | input | 1 | Negative-drive bit of the channel code |
| pos_i | input | 1 | Positive-drive bit of the channel code |
| mode_i | input | 1 | 1 selects external-CW operation |
| pscale_i | input | 1 | 0 reduces rail-1 drive strength in mode 0 |
| oe_i | input | 1 | Output enable |
| reg_en_i | input | 1 | Regulator enable |
| otp_n_i | input | 1 | Over-temperature flag, low when tripped |
| retime_mode_i | input | 1 | Retimed operation selected |
| rclk_seen_i | input | 1 | Clock-activity detector reports the clock running |
| stage_o | output | 6 | One-hot output-stage command |
| rail1_reduced_o | output | 1 | Reduced rail-1 drive strength |
| tr_sw_o | output | 1 | T/R switch enable |
| bleed_sw_o | output | 1 | Return-to-zero bleed switch enable |
| damp_sw_o | output | 1 | Receive damper enable |
| cw_sw_o | output | 1 | CW switch enable |
| err_o | output | 1 | Sticky protocol-error flag |

## Verification
The decoder is tried with random codes crossed with random mode, power-scale and enable levels, with the enables biased toward active. This separates the 1x0/0x0 rail choices from the receive and high-impedance codes, and shows that power-scale does not affect the stage. Directed sequences take each switch through a receive window. Samples are taken one edge before and at the delay boundary, so an off-by-one count or swapped on/off delays shows up. A target that reverses early shows whether the cancellation works, and dropping an enable during a receive window shows the immediate forcing. The retiming path is checked one cycle before and after a code change. The error flag is checked with the legal 011-000-transmit order and with the illegal 011-transmit order, so a flag that sets too eagerly is caught as well as one that never sets.

// File: rtl/pulser_pkg.sv
package pulser_pkg;

  localparam int unsigned STAGE_W = 6;

  localparam logic [STAGE_W-1:0] ST_HI0 = 6'b000001;
  localparam logic [STAGE_W-1:0] ST_HI1 = 6'b000010;
  localparam logic [STAGE_W-1:0] ST_LO0 = 6'b000100;
  localparam logic [STAGE_W-1:0] ST_LO1 = 6'b001000;
  localparam logic [STAGE_W-1:0] ST_RTZ = 6'b010000;
  localparam logic [STAGE_W-1:0] ST_HIZ = 6'b100000;

  localparam logic [2:0] CODE_RX = 3'b011;
  localparam logic [2:0] CODE_Z0 = 3'b000;

  typedef struct packed {
    logic [STAGE_W-1:0] stage;
    logic               rx;   // receive state: T/R + bleed target on
    logic               cw;   // CW switch target
  } dec_t;

  function automatic dec_t pulser_decode(input logic en, input logic mode,
                                         input logic [2:0] code);
    dec_t d;
    d.stage = ST_HIZ;
    d.rx    = 1'b0;
    d.cw    = 1'b0;
    if (en) begin
      if (code == CODE_RX) begin
        d.stage = ST_RTZ;
        d.rx    = 1'b1;
      end else if (mode) begin
        d.cw = 1'b1;
      end else begin
        case (code)
          3'b000, 3'b100: d.stage = ST_RTZ;
          3'b001:         d.stage = ST_HI0;
          3'b010:         d.stage = ST_LO0;
          3'b101:         d.stage = ST_HI1;
          3'b110:         d.stage = ST_LO1;
          default:        d.stage = ST_HIZ;
        endcase
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/pulser_sw_delay.sv
module pulser_sw_delay #(
  parameter int unsigned ON_CYC  = 2,
  parameter int unsigned OFF_CYC = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic target_i,
  input  logic force_i,
  input  logic force_val_i,
  output logic sw_o
);
  localparam int unsigned MAXC  = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
  localparam int unsigned CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] need;
  logic             sw_q;

  assign need = target_i ? CNT_W'(ON_CYC - 1) : CNT_W'(OFF_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q  <= RST_VAL;
      cnt_q <= '0;
    end else if (force_i) begin
      sw_q  <= force_val_i;
      cnt_q <= '0;
    end else if (target_i == sw_q) begin
      cnt_q <= '0;
    end else if (cnt_q >= need) begin
      sw_q  <= target_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sw_o = sw_q;
endmodule

// File: rtl/pulser_retime.sv
module pulser_retime (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       use_reg_i,
  input  logic [2:0] code_i,
  output logic [2:0] code_o
);
  logic [2:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= 3'b000;
    else        code_q <= code_i;
  end

  assign code_o = use_reg_i ? code_q : code_i;
endmodule

// File: rtl/pulser_proto_mon.sv
module pulser_proto_mon (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] code_i,
  input  logic       retime_mode_i,
  input  logic       rclk_seen_i,
  input  logic       drive_raw_i,
  output logic       err_o
);
  logic after_rx_q;
  logic err_q;
  logic tx_code;
  logic early_drive;

  assign tx_code     = code_i[1] ^ code_i[0];
  assign early_drive = retime_mode_i & ~rclk_seen_i & drive_raw_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      after_rx_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      if (code_i == pulser_pkg::CODE_RX)      after_rx_q <= 1'b1;
      else if (code_i == pulser_pkg::CODE_Z0) after_rx_q <= 1'b0;
      if ((after_rx_q && tx_code) || early_drive) err_q <= 1'b1;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/pulser_chan_ctrl.sv
module pulser_chan_ctrl
  import pulser_pkg::*;
#(
  parameter int unsigned TR_ON     = 23,
  parameter int unsigned TR_OFF    = 2,
  parameter int unsigned BLEED_ON  = 23,
  parameter int unsigned BLEED_OFF = 3,
  parameter int unsigned DMP_ON    = 2,
  parameter int unsigned DMP_OFF   = 175,
  parameter int unsigned CW_ON     = 4,
  parameter int unsigned CW_OFF    = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_i,
  input  logic         neg_i,
  input  logic         pos_i,
  input  logic         mode_i,
  input  logic         pscale_i,
  input  logic         oe_i,
  input  logic         reg_en_i,
  input  logic         otp_n_i,
  input  logic         retime_mode_i,
  input  logic         rclk_seen_i,
  output logic [5:0]   stage_o,
  output logic         rail1_reduced_o,
  output logic         tr_sw_o,
  output logic         bleed_sw_o,
  output logic         damp_sw_o,
  output logic         cw_sw_o,
  output logic         err_o
);
  localparam int unsigned NSW = 4;  // 0 T/R, 1 bleed, 2 damper, 3 CW
  localparam int unsigned ON_TAB  [NSW] = '{TR_ON,  BLEED_ON,  DMP_ON,  CW_ON};
  localparam int unsigned OFF_TAB [NSW] = '{TR_OFF, BLEED_OFF, DMP_OFF, CW_OFF};

  logic [2:0]     code_raw;
  logic [2:0]     code_eff;
  logic           enabled;
  dec_t           dec;
  logic [NSW-1:0] sw_tgt;
  logic [NSW-1:0] sw_q;

  assign code_raw = {sel_i, neg_i, pos_i};
  // R4: priority order otp_n, reg_en, oe; all give the same forced state
  assign enabled  = otp_n_i & reg_en_i & oe_i;

  pulser_retime u_retime (
    .clk       (clk),
    .rst_n     (rst_n),
    .use_reg_i (retime_mode_i & rclk_seen_i),
    .code_i    (code_raw),
    .code_o    (code_eff)
  );

  assign dec = pulser_decode(enabled, mode_i, code_eff);

  assign sw_tgt = {dec.cw, ~dec.rx, dec.rx, dec.rx};

  for (genvar g = 0; g < NSW; g++) begin : g_sw
    pulser_sw_delay #(
      .ON_CYC  (ON_TAB[g]),
      .OFF_CYC (OFF_TAB[g]),
      .RST_VAL (g == 2)
    ) u_dly (
      .clk         (clk),
      .rst_n       (rst_n),
      .target_i    (sw_tgt[g]),
      .force_i     (~enabled),
      .force_val_i (g == 2),
      .sw_o        (sw_q[g])
    );
  end

  pulser_proto_mon u_mon (
    .clk           (clk),
    .rst_n         (rst_n),
    .code_i        (code_eff),
    .retime_mode_i (retime_mode_i),
    .rclk_seen_i   (rclk_seen_i),
    .drive_raw_i   (neg_i | pos_i),
    .err_o         (err_o)
  );

  assign stage_o         = dec.stage;
  assign rail1_reduced_o = enabled & ~mode_i & ~pscale_i;
  assign tr_sw_o         = sw_q[0];
  assign bleed_sw_o      = sw_q[1];
  assign damp_sw_o       = sw_q[2];
  assign cw_sw_o         = sw_q[3];
endmodule

// File: rtl/pulser_chan_chk.sv
module pulser_chan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_i,
  input logic       neg_i,
  input logic       pos_i,
  input logic       mode_i,
  input logic       pscale_i,
  input logic       oe_i,
  input logic       reg_en_i,
  input logic       otp_n_i,
  input logic       retime_mode_i,
  input logic       rclk_seen_i,
  input logic [5:0] stage_o,
  input logic       rail1_reduced_o,
  input logic       tr_sw_o,
  input logic       bleed_sw_o,
  input logic       damp_sw_o,
  input logic       cw_sw_o,
  input logic       err_o
);
  // R1
  stage_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stage_o) == 1);

  // R4
  disable_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!otp_n_i || !reg_en_i || !oe_i) |-> stage_o == 6'b100000);

  // R4
  disable_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!otp_n_i || !reg_en_i || !oe_i) |=>
      (!tr_sw_o && !bleed_sw_o && !cw_sw_o && damp_sw_o));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  // R6
  tr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tr_sw_o) |-> $past(stage_o[4]));

  // R7
  damp_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(damp_sw_o) |-> $past(stage_o[4]));

  // R8
  cw_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cw_sw_o) |-> $past(mode_i));
endmodule

bind pulser_chan_ctrl pulser_chan_chk u_chk (.*);

// File: tb/tb_pulser_chan_ctrl.sv
module tb_pulser_chan_ctrl;
  localparam int unsigned P_TR_ON = 23, P_TR_OFF = 2, P_BL_ON = 23, P_BL_OFF = 3;
  localparam int unsigned P_DM_ON = 2, P_DM_OFF = 175, P_CW_ON = 4, P_CW_OFF = 2;
  localparam logic [5:0] E_HI0 = 6'b000001, E_HI1 = 6'b000010, E_LO0 = 6'b000100;
  localparam logic [5:0] E_LO1 = 6'b001000, E_RTZ = 6'b010000, E_HIZ = 6'b100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_i = 0, neg_i = 0, pos_i = 0, mode_i = 0, pscale_i = 1;
  logic oe_i = 1, reg_en_i = 1, otp_n_i = 1, retime_mode_i = 0, rclk_seen_i = 0;
  logic [5:0] stage_o;
  logic rail1_reduced_o, tr_sw_o, bleed_sw_o, damp_sw_o, cw_sw_o, err_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pulser_chan_ctrl #(
    .TR_ON(P_TR_ON), .TR_OFF(P_TR_OFF), .BLEED_ON(P_BL_ON), .BLEED_OFF(P_BL_OFF),
    .DMP_ON(P_DM_ON), .DMP_OFF(P_DM_OFF), .CW_ON(P_CW_ON), .CW_OFF(P_CW_OFF)
  ) dut (.*);

  function automatic logic [5:0] exp_stage(logic en, logic md, logic [2:0] c);
    if (!en) return E_HIZ;
    if (c == 3'b011) return E_RTZ;
    if (md) return E_HIZ;
    case (c)
      3'b001: return E_HI0;
      3'b010: return E_LO0;
      3'b101: return E_HI1;
      3'b110: return E_LO1;
      3'b111: return E_HIZ;
      default: return E_RTZ;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic set_code(logic [2:0] c);
    {sel_i, neg_i, pos_i} = c;
  endtask

  task automatic do_reset();
    rst_n = 0;
    set_code(3'b000);
    mode_i = 0; pscale_i = 1; oe_i = 1; reg_en_i = 1; otp_n_i = 1;
    retime_mode_i = 0; rclk_seen_i = 0;
    tick(2);
    rst_n = 1;
    tick(1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R13 reset state
    chk("R13 tr", tr_sw_o, 0);
    chk("R13 bleed", bleed_sw_o, 0);
    chk("R13 cw", cw_sw_o, 0);
    chk("R13 damp", damp_sw_o, 1);
    chk("R13 err", err_o, 0);
    chk("R1 rtz idle", stage_o, E_RTZ);

    // R2/R6/R7: receive window timing
    set_code(3'b011); #1;
    chk("R2 rx stage", stage_o, E_RTZ);
    tick(P_TR_ON - 1);
    chk("R6 tr before on", tr_sw_o, 0);
    chk("R6 bleed before on", bleed_sw_o, 0);
    tick(1);
    chk("R6 tr on", tr_sw_o, 1);
    chk("R6 bleed on", bleed_sw_o, 1);
    tick(P_DM_OFF - P_TR_ON - 1);
    chk("R7 damp before off", damp_sw_o, 1);
    tick(1);
    chk("R7 damp off", damp_sw_o, 0);
    set_code(3'b000);
    tick(1);
    chk("R6 tr hold", tr_sw_o, 1);
    chk("R7 damp still off", damp_sw_o, 0);
    tick(1);
    chk("R6 tr off", tr_sw_o, 0);
    chk("R7 damp on", damp_sw_o, 1);
    chk("R6 bleed hold", bleed_sw_o, 1);
    tick(1);
    chk("R6 bleed off", bleed_sw_o, 0);

    // R9 cancellation
    set_code(3'b011); tick(10);
    set_code(3'b000); tick(30);
    chk("R9 tr cancelled", tr_sw_o, 0);
    chk("R9 bleed cancelled", bleed_sw_o, 0);
    chk("R9 damp unchanged", damp_sw_o, 1);

    // R4 forcing during receive
    set_code(3'b011); tick(P_DM_OFF + 5);
    chk("R4 pre tr", tr_sw_o, 1);
    oe_i = 0; #1;
    chk("R4 oe hiz", stage_o, E_HIZ);
    tick(1);
    chk("R4 tr forced", tr_sw_o, 0);
    chk("R4 bleed forced", bleed_sw_o, 0);
    chk("R4 damp forced", damp_sw_o, 1);
    oe_i = 1; set_code(3'b000); tick(2);

    // R3/R8 CW mode
    mode_i = 1; #1;
    chk("R3 cw hiz", stage_o, E_HIZ);
    tick(P_CW_ON - 1);
    chk("R8 cw before on", cw_sw_o, 0);
    tick(1);
    chk("R8 cw on", cw_sw_o, 1);
    set_code(3'b011); #1;
    chk("R3 cw rx stage", stage_o, E_RTZ);
    tick(P_CW_OFF - 1);
    chk("R8 cw before off", cw_sw_o, 1);
    tick(1);
    chk("R8 cw off", cw_sw_o, 0);
    mode_i = 0; set_code(3'b000); tick(P_DM_OFF + 5);

    // R10 retiming
    retime_mode_i = 1; rclk_seen_i = 1; tick(1);
    set_code(3'b001); #1;
    chk("R10 retimed hold", stage_o, E_RTZ);
    tick(1);
    chk("R10 retimed update", stage_o, E_HI0);
    rclk_seen_i = 0; set_code(3'b010); #1;
    chk("R10 transparent", stage_o, E_LO0);
    retime_mode_i = 0; set_code(3'b000); tick(1);

    // R1/R3/R4/R5 random decode
    for (int i = 0; i < 300; i++) begin
      logic [2:0] c;
      logic en;
      c = 3'($urandom);
      set_code(c);
      mode_i = 1'($urandom);
      pscale_i = 1'($urandom);
      otp_n_i = ($urandom % 8) != 0;
      reg_en_i = ($urandom % 8) != 0;
      oe_i = ($urandom % 8) != 0;
      retime_mode_i = 1'($urandom);
      rclk_seen_i = 1'($urandom);
      en = otp_n_i & reg_en_i & oe_i;
      tick(1);
      chk("R1/R3/R4 decode", stage_o, exp_stage(en, mode_i, c));
      chk("R5 rail1 reduced", rail1_reduced_o, en & ~mode_i & ~pscale_i);
    end

    // R11 protocol error
    do_reset();
    set_code(3'b011); tick(1);
    set_code(3'b000); tick(1);
    set_code(3'b001); tick(1);
    chk("R11 legal order", err_o, 0);
    set_code(3'b011); tick(1);
    set_code(3'b110); tick(1);
    chk("R11 illegal order", err_o, 1);
    set_code(3'b000); tick(2);
    chk("R11 sticky", err_o, 1);

    // R12 early drive in retimed mode
    do_reset();
    retime_mode_i = 1; rclk_seen_i = 0; tick(1);
    chk("R12 idle ok", err_o, 0);
    set_code(3'b001); tick(1);
    chk("R12 early drive", err_o, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule